// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits behind the host write path of a byte-wide flash array. It watches the bus write cycles and recognizes the multi-cycle unlock sequences that guard every data-altering operation. Each write arrives as a one-cycle strobe with an address and a data byte. When a complete sequence has been seen, the block raises a single-cycle request for one of five operations: byte program, sector erase, chip erase, entry into identification mode, or exit from it. The target address and data travel with the request.

Every sequence opens with the same two unlock writes. The third write then selects program, erase or identification entry. A program sequence takes its target on the fourth write. An erase sequence needs a second unlock pair and then an erase code on the sixth write. Any write that breaks the expected order discards the partial sequence. While the array controller reports an operation in progress, all writes are ignored and any partial sequence is held as it is.

The block also holds the identification-mode flag. While that flag is set, reads of address 0 and address 1 return fixed manufacturer and device codes. All other reads pass the array data through unchanged.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, id_mode is 0, every request output is 0, and rd_data equals array_rdata for every rd_addr.
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by a fourth write of any data to any address, raise prog_req during the fourth write's strobe cycle, with tgt_addr equal to that write's full address and tgt_data equal to its data.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 10h@555h raise chip_erase_req during the sixth write's strobe cycle.
- R4: The same five-write erase prefix followed by 20h written to any address raises sect_erase_req during that write's cycle. tgt_addr equals the written address with bits 6..0 cleared, which names a 128-byte sector.
- R5: The writes AAh@555h, 55h@2AAh and 90h@555h raise id_enter_req during the third write's cycle, and id_mode reads 1 from the next clock edge.
- R6: From idle, a single write of F0h to any address raises id_exit_req. The sequence AAh@555h, 55h@2AAh, F0h@555h does the same. id_mode reads 0 from the next clock edge.
- R7: Only address bits 14..0 take part in matching. Higher address bits are don't-care, and a difference in bits 14..0 breaks a match.
- R8: A write that does not match the expected step of a partial sequence discards that sequence and raises no request. That write does not start a new sequence, so a following A0h write followed by a data write does not program.
- R9: While busy is 1, writes raise no request, do not change id_mode, and leave the partial sequence unchanged, so the sequence can continue once busy returns to 0.
- R10: While id_mode is 1, rd_data is MFR_CODE when rd_addr is 0, DEV_CODE when rd_addr is 1, and array_rdata at any other address.
- R11: At most one request is high in any cycle. A request is high only in a cycle where wr_stb is 1, so it lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | An internal program or erase operation is in progress |
| rd_addr | input | ADDR_W | Read address |
| array_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data returned to the host |
| id_mode | output | 1 | Identification mode is active |
| prog_req | output | 1 | Byte program request pulse |
| sect_erase_req | output | 1 | Sector erase request pulse |
| chip_erase_req | output | 1 | Chip erase request pulse |
| id_enter_req | output | 1 | Identification entry pulse |
| id_exit_req | output | 1 | Identification exit pulse |
| tgt_addr | output | ADDR_W | Target address that accompanies a request |
| tgt_data | output | 8 | Target data that accompanies a request |

## Verification
The bench targets the places where a sloppy decoder goes wrong:
- Address bits above bit 14 are set in the unlock writes. A decoder that compares the full address would never unlock.
- A bit inside the low 15 is flipped. A decoder that masks too much would unlock anyway.
- A write breaks a sequence midway and a would-be program follows. A decoder that replays the breaking write as a new first step, or does not reset at all, would issue a stray program.
- Writes arrive while busy is high. A decoder that lets them through would leave identification mode early, or lose the partial sequence that should survive.
- A sector erase is sent to an unaligned address. An unmasked target address would show up on tgt_addr.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;

  // Sequence position: how many steps of which prefix are already accepted
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_U1,
    SQ_U2,
    SQ_PROG,
    SQ_E3,
    SQ_E4,
    SQ_E5
  } seq_t;

  // Request vector bit positions
  localparam int REQ_PROG  = 0;
  localparam int REQ_SECT  = 1;
  localparam int REQ_CHIP  = 2;
  localparam int REQ_IDIN  = 3;
  localparam int REQ_IDOUT = 4;
  localparam int NREQ      = 5;

  // Write patterns recognized by the matcher
  localparam int P_UNLK1  = 0;
  localparam int P_UNLK2  = 1;
  localparam int P_PROG   = 2;
  localparam int P_ERASE  = 3;
  localparam int P_IDIN   = 4;
  localparam int P_IDOUT3 = 5;
  localparam int P_CHIP   = 6;
  localparam int P_SECT   = 7;
  localparam int P_IDOUT1 = 8;
  localparam int NPAT     = 9;

  localparam logic [15:0] ADR_A = 16'h0555;
  localparam logic [15:0] ADR_B = 16'h02AA;

  function automatic logic [15:0] pat_addr(input int i);
    case (i)
      P_UNLK2: return ADR_B;
      default: return ADR_A;
    endcase
  endfunction

  function automatic logic [7:0] pat_data(input int i);
    case (i)
      P_UNLK1:  return 8'hAA;
      P_UNLK2:  return 8'h55;
      P_PROG:   return 8'hA0;
      P_ERASE:  return 8'h80;
      P_IDIN:   return 8'h90;
      P_CHIP:   return 8'h10;
      P_SECT:   return 8'h20;
      default:  return 8'hF0;
    endcase
  endfunction

  // Patterns whose address is don't-care
  function automatic logic pat_any_addr(input int i);
    return (i == P_SECT) || (i == P_IDOUT1);
  endfunction

endpackage

// File: rtl/fcd_pattern_match.sv
`timescale 1ns/1ps
module fcd_pattern_match #(
  parameter int ADDR_W  = 19,
  parameter int MATCH_W = 15
) (
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  output logic [fcd_pkg::NPAT-1:0] hit
);
  import fcd_pkg::*;

  localparam logic [ADDR_W-1:0] MATCH_MASK = ADDR_W'((64'd1 << MATCH_W) - 64'd1);

  logic [ADDR_W-1:0] addr_low;
  assign addr_low = wr_addr & MATCH_MASK;

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    localparam logic [ADDR_W-1:0] PA = ADDR_W'(pat_addr(g));
    localparam logic [7:0]        PD = pat_data(g);
    localparam bit                ANY = pat_any_addr(g);
    if (ANY) begin : g_any
      assign hit[g] = (wr_data == PD);
    end else begin : g_fix
      assign hit[g] = (wr_data == PD) && (addr_low == PA);
    end
  end

endmodule

// File: rtl/fcd_seq_fsm.sv
`timescale 1ns/1ps
module fcd_seq_fsm (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_accept,
  input  logic [fcd_pkg::NPAT-1:0] hit,
  output fcd_pkg::seq_t            seq_state,
  output logic [fcd_pkg::NREQ-1:0] req
);
  import fcd_pkg::*;

  seq_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    req     = '0;
    if (wr_accept) begin
      state_d = SQ_IDLE;
      case (state_q)
        SQ_IDLE: begin
          if (hit[P_UNLK1])       state_d = SQ_U1;
          else if (hit[P_IDOUT1]) req[REQ_IDOUT] = 1'b1;
        end
        SQ_U1: if (hit[P_UNLK2]) state_d = SQ_U2;
        SQ_U2: begin
          if (hit[P_PROG])        state_d = SQ_PROG;
          else if (hit[P_ERASE])  state_d = SQ_E3;
          else if (hit[P_IDIN])   req[REQ_IDIN] = 1'b1;
          else if (hit[P_IDOUT3]) req[REQ_IDOUT] = 1'b1;
        end
        SQ_PROG: req[REQ_PROG] = 1'b1;
        SQ_E3: if (hit[P_UNLK1]) state_d = SQ_E4;
        SQ_E4: if (hit[P_UNLK2]) state_d = SQ_E5;
        SQ_E5: begin
          if (hit[P_CHIP])      req[REQ_CHIP] = 1'b1;
          else if (hit[P_SECT]) req[REQ_SECT] = 1'b1;
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign seq_state = state_q;

endmodule

// File: rtl/fcd_id_ctrl.sv
`timescale 1ns/1ps
module fcd_id_ctrl #(
  parameter int          ADDR_W   = 19,
  parameter logic [7:0]  MFR_CODE = 8'h5E,
  parameter logic [7:0]  DEV_CODE = 8'hA7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter,
  input  logic              leave,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_rdata,
  output logic              id_mode,
  output logic [7:0]        rd_data
);

  logic mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= 1'b0;
    else if (enter)  mode_q <= 1'b1;
    else if (leave)  mode_q <= 1'b0;
  end

  function automatic logic [7:0] id_read(input logic mode, input logic [ADDR_W-1:0] a,
                                         input logic [7:0] arr);
    if (mode && a == ADDR_W'(0)) return MFR_CODE;
    if (mode && a == ADDR_W'(1)) return DEV_CODE;
    return arr;
  endfunction

  assign id_mode = mode_q;
  assign rd_data = id_read(mode_q, rd_addr, array_rdata);

endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder #(
  parameter int         ADDR_W   = 19,
  parameter int         MATCH_W  = 15,
  parameter int         SECT_LSB = 7,
  parameter logic [7:0] MFR_CODE = 8'h5E,
  parameter logic [7:0] DEV_CODE = 8'hA7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_rdata,
  output logic [7:0]        rd_data,
  output logic              id_mode,
  output logic              prog_req,
  output logic              sect_erase_req,
  output logic              chip_erase_req,
  output logic              id_enter_req,
  output logic              id_exit_req,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [7:0]        tgt_data
);
  import fcd_pkg::*;

  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((64'd1 << SECT_LSB) - 64'd1);

  function automatic logic [ADDR_W-1:0] sector_base(input logic [ADDR_W-1:0] a);
    return a & ~SECT_MASK;
  endfunction

  // Named internal events for the checker
  logic            wr_accept;
  logic [NPAT-1:0] hit;
  logic [NREQ-1:0] req_vec;
  seq_t            seq_state;

  assign wr_accept = wr_stb & ~busy;

  fcd_pattern_match #(.ADDR_W(ADDR_W), .MATCH_W(MATCH_W)) match_i (
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hit     (hit)
  );

  fcd_seq_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_accept (wr_accept),
    .hit       (hit),
    .seq_state (seq_state),
    .req       (req_vec)
  );

  fcd_id_ctrl #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) id_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter       (req_vec[REQ_IDIN]),
    .leave       (req_vec[REQ_IDOUT]),
    .rd_addr     (rd_addr),
    .array_rdata (array_rdata),
    .id_mode     (id_mode),
    .rd_data     (rd_data)
  );

  assign prog_req       = req_vec[REQ_PROG];
  assign sect_erase_req = req_vec[REQ_SECT];
  assign chip_erase_req = req_vec[REQ_CHIP];
  assign id_enter_req   = req_vec[REQ_IDIN];
  assign id_exit_req    = req_vec[REQ_IDOUT];
  assign tgt_addr       = req_vec[REQ_SECT] ? sector_base(wr_addr) : wr_addr;
  assign tgt_data       = wr_data;

endmodule

// File: rtl/fcd_checker.sv
`timescale 1ns/1ps
module fcd_checker #(
  parameter int ADDR_W   = 19,
  parameter int SECT_LSB = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_stb,
  input logic                     busy,
  input logic [fcd_pkg::NREQ-1:0] req_vec,
  input logic                     id_mode,
  input logic [ADDR_W-1:0]        tgt_addr,
  input fcd_pkg::seq_t            seq_state
);
  import fcd_pkg::*;

  // R11
  one_hot_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_vec));

  // R11
  req_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_vec) |-> wr_stb);

  // R9
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (req_vec == '0));

  // R9
  busy_holds_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(seq_state));

  // R9
  busy_holds_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(id_mode));

  // R5
  id_enter_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vec[REQ_IDIN] |=> id_mode);

  // R6
  id_exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vec[REQ_IDOUT] |=> !id_mode);

  // R4
  sector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vec[REQ_SECT] |-> (tgt_addr[SECT_LSB-1:0] == '0));

  // R2
  prog_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vec[REQ_PROG] |-> (seq_state == SQ_PROG));

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_stb    (wr_stb),
  .busy      (busy),
  .req_vec   (req_vec),
  .id_mode   (id_mode),
  .tgt_addr  (tgt_addr),
  .seq_state (seq_state)
);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;

  localparam int         AW  = 19;
  localparam logic [7:0] MFR = 8'h5E;
  localparam logic [7:0] DEV = 8'hA7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          busy = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    array_rdata = 8'h3C;
  logic [7:0]    rd_data;
  logic          id_mode;
  logic          prog_req, sect_erase_req, chip_erase_req, id_enter_req, id_exit_req;
  logic [AW-1:0] tgt_addr;
  logic [7:0]    tgt_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [AW-1:0] cap_addr;
  logic [7:0]    cap_data;

  // bench-side request order: {exit, enter, chip, sector, program}
  localparam logic [4:0] NONE = 5'b00000, PRG = 5'b00001, SEC = 5'b00010,
                         CHP = 5'b00100, ENT = 5'b01000, EXT = 5'b10000;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .MFR_CODE(MFR), .DEV_CODE(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data),
    .id_mode(id_mode), .prog_req(prog_req), .sect_erase_req(sect_erase_req),
    .chip_erase_req(chip_erase_req), .id_enter_req(id_enter_req),
    .id_exit_req(id_exit_req), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  function automatic logic [4:0] reqs();
    return {id_exit_req, id_enter_req, chip_erase_req, sect_erase_req, prog_req};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One write: strobe for one cycle, requests sampled before the edge,
  // then the cycle after must carry no request.
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input logic [4:0] exp, input string tag);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    #1;
    check(reqs() == exp, tag, 32'(reqs()), 32'(exp));
    cap_addr = tgt_addr; cap_data = tgt_data;
    @(negedge clk);
    wr_stb = 1'b0;
    #1;
    if (exp != NONE) check(reqs() == NONE, "R11 pulse width", 32'(reqs()), 0);
  endtask

  task automatic unlock(input logic [AW-1:0] hi);
    wr(hi | 19'h555, 8'hAA, NONE, "R8 unlock1");
    wr(hi | 19'h2AA, 8'h55, NONE, "R8 unlock2");
  endtask

  task automatic t_reset();
    check(id_mode == 1'b0, "R1 id_mode", 32'(id_mode), 0);
    check(reqs() == NONE, "R1 requests", 32'(reqs()), 0);
    rd_addr = 19'h0; #1;
    check(rd_data == 8'h3C, "R1 read addr0", 32'(rd_data), 32'h3C);
    rd_addr = 19'h1; #1;
    check(rd_data == 8'h3C, "R1 read addr1", 32'(rd_data), 32'h3C);
  endtask

  task automatic t_program();
    unlock('0);
    wr(19'h555, 8'hA0, NONE, "R2 arm");
    wr(19'h12345, 8'h5A, PRG, "R2 program pulse R11");
    check(cap_addr == 19'h12345, "R2 tgt_addr", 32'(cap_addr), 32'h12345);
    check(cap_data == 8'h5A, "R2 tgt_data", 32'(cap_data), 32'h5A);
  endtask

  task automatic t_high_bits();
    wr(19'h78555, 8'hAA, NONE, "R7 hi1");
    wr(19'h782AA, 8'h55, NONE, "R7 hi2");
    wr(19'h40555, 8'hA0, NONE, "R7 hi3");
    wr(19'h00077, 8'h11, PRG, "R7 upper bits ignored");
    wr(19'h01555, 8'hAA, NONE, "R7 bit12 set");
    wr(19'h002AA, 8'h55, NONE, "R7 b");
    wr(19'h00555, 8'hA0, NONE, "R7 c");
    wr(19'h00100, 8'h33, NONE, "R7 low bit difference breaks match");
  endtask

  task automatic t_chip();
    unlock('0);
    wr(19'h555, 8'h80, NONE, "R3 e3");
    unlock('0);
    wr(19'h555, 8'h10, CHP, "R3 chip erase");
  endtask

  task automatic t_sector();
    unlock('0);
    wr(19'h555, 8'h80, NONE, "R4 e3");
    unlock('0);
    wr(19'h12F7F, 8'h20, SEC, "R4 sector erase");
    check(cap_addr == 19'h12F00, "R4 sector base", 32'(cap_addr), 32'h12F00);
  endtask

  task automatic t_id();
    unlock('0);
    wr(19'h555, 8'h90, ENT, "R5 id entry");
    check(id_mode == 1'b1, "R5 id_mode set", 32'(id_mode), 1);
    rd_addr = 19'h0; #1;
    check(rd_data == MFR, "R10 manufacturer", 32'(rd_data), 32'(MFR));
    rd_addr = 19'h1; #1;
    check(rd_data == DEV, "R10 device", 32'(rd_data), 32'(DEV));
    rd_addr = 19'h2; #1;
    check(rd_data == 8'h3C, "R10 passthrough", 32'(rd_data), 32'h3C);
    wr(19'h3333, 8'hF0, EXT, "R6 single exit");
    check(id_mode == 1'b0, "R6 id_mode cleared", 32'(id_mode), 0);
    rd_addr = 19'h0; #1;
    check(rd_data == 8'h3C, "R6 read after exit", 32'(rd_data), 32'h3C);
    unlock('0);
    wr(19'h555, 8'h90, ENT, "R5 reenter");
    unlock('0);
    wr(19'h555, 8'hF0, EXT, "R6 three-cycle exit");
    check(id_mode == 1'b0, "R6 id_mode cleared 3c", 32'(id_mode), 0);
  endtask

  task automatic t_abort();
    unlock('0);
    wr(19'h555, 8'h77, NONE, "R8 bad third");
    wr(19'h555, 8'hA0, NONE, "R8 no restart");
    wr(19'h100, 8'h5A, NONE, "R8 no program after abort");
    unlock('0);
    wr(19'h555, 8'h80, NONE, "R8 e3");
    wr(19'h555, 8'hAA, NONE, "R8 e4");
    wr(19'h2AA, 8'h99, NONE, "R8 bad fifth");
    wr(19'h555, 8'h10, NONE, "R8 no chip erase after abort");
  endtask

  task automatic t_busy();
    unlock('0);
    wr(19'h555, 8'h90, ENT, "R9 setup entry");
    busy = 1'b1;
    wr(19'h0, 8'hF0, NONE, "R9 exit ignored");
    check(id_mode == 1'b1, "R9 id_mode kept", 32'(id_mode), 1);
    busy = 1'b0;
    wr(19'h0, 8'hF0, EXT, "R9 exit after busy");
    unlock('0);
    busy = 1'b1;
    wr(19'h555, 8'h77, NONE, "R9 breaking write ignored");
    busy = 1'b0;
    wr(19'h555, 8'hA0, NONE, "R9 continue arm");
    wr(19'h00ABC, 8'hC3, PRG, "R9 sequence survived busy");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_high_bits();
    t_chip();
    t_sector();
    t_id();
    t_abort();
    t_busy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule